// File: doc/BRIEF.md
# Quad UART Receive Read Sequencer

This block drains received bytes from a four-channel UART device. It watches the four interrupt lines from the device. When a line is high, it runs a fixed chain of three register reads on that channel. It first reads the interrupt identification register. If that register reports received data, it reads the line status register. If the data-available bit is set there, it reads the receive holding register. The byte is then presented on the output together with a 3-bit code that names the channel.

The block does not toggle device pins itself. It hands a register address, a request strobe and the channel code to a lower-level bus-cycle generator. It then waits for that generator's done strobe before it takes the next step. The done cycle also carries the read data.

Inside, the machine has one idle state and four states per channel, 17 states in all. It goes back to idle after every channel. This lets a line that rose while another channel was being served be picked up on the next pass.

Top module: `uartReadSeq`

## Requirements
- R1: During and right after reset, the outputs are as follows: busReq is 0, rxValid is 0, chanCode is 0.
- R2: In the cycle after an idle cycle in which any interrupt line is high, busReq is 1, busAddr is the interrupt identification address (default 2) and chanCode names the lowest-numbered pending line. The codes are 1 for line 0, 2 for line 1, 3 for line 2 and 4 for line 3.
- R3: While busDone is low, an issued request stays up and busAddr and chanCode do not change. The sequence advances only on a cycle with busReq and busDone both high.
- R4: If the identification value captured on busDone equals 0x04, the next cycle requests the line status address (default 5). Any other value returns the block to idle in the cycle after the next, with no further request and no byte.
- R5: If bit 0 of the captured line status is 1, the next cycle requests the receive holding address (default 0). If the bit is 0, the block returns to idle with no holding-register read and no byte.
- R6: The cycle after the holding-register read completes, rxValid is high for exactly one cycle. In that cycle rxByte is the data returned by that read and chanCode is the channel code.
- R7: When several lines are pending, channels are served one at a time in the order line 0, 1, 2, 3. There is an idle cycle between channels.
- R8: Interrupt lines that change while a channel is being served do not affect that channel's sequence or its code. A line raised during the sequence is served after it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rstN | input | 1 | Active-low synchronous reset |
| irqLines | input | 4 | Interrupt lines from the four UART channels, bit i for channel i |
| busReq | output | 1 | Register read request to the bus-cycle generator |
| busAddr | output | 3 | Register address of the requested read, 0 when idle |
| busDone | input | 1 | Generator finished the current read; busData valid |
| busData | input | 8 | Read data returned with busDone |
| chanCode | output | 3 | Channel code (1 to 4) for the current request or delivered byte |
| rxValid | output | 1 | One-cycle strobe: rxByte holds a received byte |
| rxByte | output | 8 | Received byte |

## Verification
A wrong state register shows at the ports in the next cycle. The request strobe or its address then departs from the reference, or rxValid fires without a holding-register read. A wrong captured value or channel code shows as a wrong address after a status read, or as a wrong byte or code with rxValid. The per-clock comparison catches either one in the cycle it happens. The directed cases add ordering checks on the delivered stream and access counts. These expose sequences that were skipped or repeated, which a single cycle cannot reveal.

// File: rtl/uartSeqPkg.sv
package uartSeqPkg;
  localparam int NUM_CH = 4;
  localparam int CH_W = $clog2(NUM_CH);
  localparam int CODE_W = $clog2(NUM_CH + 1);
  localparam int STEPS = 4;
  localparam int STATE_N = 1 + STEPS * NUM_CH;
  localparam int ST_W = $clog2(STATE_N);

  typedef enum logic [1:0] {
    PH_ISR = 2'd0,
    PH_LSR = 2'd1,
    PH_RHR = 2'd2,
    PH_OUT = 2'd3
  } phase_t;

  typedef struct packed {
    logic            loadChan;
    logic [CH_W-1:0] chanIdx;
    logic            capture;
  } seqCtl_t;
endpackage

// File: rtl/uartSeqCtrl.sv
module uartSeqCtrl
  import uartSeqPkg::*;
#(
  parameter int ADDR_W = 3,
  parameter logic [ADDR_W-1:0] ISR_ADDR = 3'd2,
  parameter logic [ADDR_W-1:0] LSR_ADDR = 3'd5,
  parameter logic [ADDR_W-1:0] RHR_ADDR = 3'd0
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [NUM_CH-1:0] irqLines,
  input  logic              busDone,
  input  logic              isrOk,
  input  logic              lsrOk,
  output logic              busReq,
  output logic [ADDR_W-1:0] busAddr,
  output logic              rxValid,
  output seqCtl_t           ctl
);
  logic [ST_W-1:0] stateQ, stateD;
  phase_t phase;
  logic isIdle;
  logic anyIrq;
  logic [CH_W-1:0] pickIdx;

  assign isIdle = (stateQ == '0);
  assign phase = phase_t'(2'(stateQ - ST_W'(1)));

  // lowest-numbered pending line wins
  always_comb begin
    anyIrq = 1'b0;
    pickIdx = '0;
    for (int i = NUM_CH - 1; i >= 0; i--) begin
      if (irqLines[i]) begin
        anyIrq = 1'b1;
        pickIdx = CH_W'(i);
      end
    end
  end

  always_comb begin
    stateD = stateQ;
    busReq = 1'b0;
    busAddr = '0;
    rxValid = 1'b0;
    ctl = '0;
    if (isIdle) begin
      if (anyIrq) begin
        ctl.loadChan = 1'b1;
        ctl.chanIdx = pickIdx;
        stateD = ST_W'(1) + ST_W'({pickIdx, 2'b00});
      end
    end else begin
      case (phase)
        PH_ISR: begin
          busReq = 1'b1;
          busAddr = ISR_ADDR;
          if (busDone) begin
            ctl.capture = 1'b1;
            stateD = stateQ + ST_W'(1);
          end
        end
        PH_LSR: begin
          if (isrOk) begin
            busReq = 1'b1;
            busAddr = LSR_ADDR;
            if (busDone) begin
              ctl.capture = 1'b1;
              stateD = stateQ + ST_W'(1);
            end
          end else begin
            stateD = '0;
          end
        end
        PH_RHR: begin
          if (lsrOk) begin
            busReq = 1'b1;
            busAddr = RHR_ADDR;
            if (busDone) begin
              ctl.capture = 1'b1;
              stateD = stateQ + ST_W'(1);
            end
          end else begin
            stateD = '0;
          end
        end
        default: begin
          rxValid = 1'b1;
          stateD = '0;
        end
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) stateQ <= '0;
    else stateQ <= stateD;
  end

  assert_idle_quiet_R1: assert property (@(posedge clk) disable iff (!rstN)
    $past(!rstN) |-> !busReq && !rxValid);

  assert_start_isr_R2: assert property (@(posedge clk) disable iff (!rstN)
    (isIdle && anyIrq) |=> busReq && busAddr == ISR_ADDR);

  assert_hold_req_R3: assert property (@(posedge clk) disable iff (!rstN)
    (busReq && !busDone) |=> busReq && $stable(busAddr));

  assert_lsr_needs_isr_R4: assert property (@(posedge clk) disable iff (!rstN)
    (busReq && busAddr == LSR_ADDR) |-> isrOk);

  assert_rhr_needs_lsr_R5: assert property (@(posedge clk) disable iff (!rstN)
    (busReq && busAddr == RHR_ADDR) |-> lsrOk);

  assert_valid_pulse_R6: assert property (@(posedge clk) disable iff (!rstN)
    rxValid |=> !rxValid && !busReq);

  assert_state_range_R7: assert property (@(posedge clk) disable iff (!rstN)
    stateQ < ST_W'(STATE_N));
endmodule

// File: rtl/uartSeqData.sv
module uartSeqData
  import uartSeqPkg::*;
#(
  parameter int DATA_W = 8,
  parameter logic [DATA_W-1:0] RX_READY_CODE = 8'h04,
  parameter int RX_AVAIL_BIT = 0
) (
  input  logic              clk,
  input  logic              rstN,
  input  seqCtl_t           ctl,
  input  logic [DATA_W-1:0] busData,
  output logic [CODE_W-1:0] chanCode,
  output logic [DATA_W-1:0] rxByte,
  output logic              isrOk,
  output logic              lsrOk
);
  logic [CODE_W-1:0] codeQ;
  logic [DATA_W-1:0] dataQ;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      codeQ <= '0;
      dataQ <= '0;
    end else begin
      if (ctl.loadChan) codeQ <= CODE_W'(ctl.chanIdx) + CODE_W'(1);
      if (ctl.capture) dataQ <= busData;
    end
  end

  assign chanCode = codeQ;
  assign rxByte = dataQ;
  assign isrOk = (dataQ == RX_READY_CODE);
  assign lsrOk = dataQ[RX_AVAIL_BIT];

  assert_code_hold_R8: assert property (@(posedge clk) disable iff (!rstN)
    !ctl.loadChan |=> $stable(chanCode));

  assert_code_range_R2: assert property (@(posedge clk) disable iff (!rstN)
    ctl.loadChan |=> chanCode >= CODE_W'(1) && chanCode <= CODE_W'(NUM_CH));
endmodule

// File: rtl/uartReadSeq.sv
module uartReadSeq
  import uartSeqPkg::*;
#(
  parameter int ADDR_W = 3,
  parameter int DATA_W = 8,
  parameter logic [ADDR_W-1:0] ISR_ADDR = 3'd2,
  parameter logic [ADDR_W-1:0] LSR_ADDR = 3'd5,
  parameter logic [ADDR_W-1:0] RHR_ADDR = 3'd0,
  parameter logic [DATA_W-1:0] RX_READY_CODE = 8'h04,
  parameter int RX_AVAIL_BIT = 0
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [NUM_CH-1:0] irqLines,
  output logic              busReq,
  output logic [ADDR_W-1:0] busAddr,
  input  logic              busDone,
  input  logic [DATA_W-1:0] busData,
  output logic [CODE_W-1:0] chanCode,
  output logic              rxValid,
  output logic [DATA_W-1:0] rxByte
);
  seqCtl_t ctl;
  logic isrOk, lsrOk;

  uartSeqCtrl #(
    .ADDR_W(ADDR_W), .ISR_ADDR(ISR_ADDR), .LSR_ADDR(LSR_ADDR), .RHR_ADDR(RHR_ADDR)
  ) ctrl_i (
    .clk(clk), .rstN(rstN), .irqLines(irqLines), .busDone(busDone),
    .isrOk(isrOk), .lsrOk(lsrOk), .busReq(busReq), .busAddr(busAddr),
    .rxValid(rxValid), .ctl(ctl)
  );

  uartSeqData #(
    .DATA_W(DATA_W), .RX_READY_CODE(RX_READY_CODE), .RX_AVAIL_BIT(RX_AVAIL_BIT)
  ) data_i (
    .clk(clk), .rstN(rstN), .ctl(ctl), .busData(busData),
    .chanCode(chanCode), .rxByte(rxByte), .isrOk(isrOk), .lsrOk(lsrOk)
  );
endmodule

// File: tb/uartReadSeq_tb.sv
`timescale 1ns/1ps
module uartReadSeq_tb_top;
  logic clk = 1'b0;
  always #2.5 clk = ~clk;

  logic rstN;
  logic [3:0] irqLines;
  logic busReq, busDone, rxValid;
  logic [2:0] busAddr, chanCode;
  logic [7:0] busData, rxByte;

  uartReadSeq dut_i (
    .clk(clk), .rstN(rstN), .irqLines(irqLines), .busReq(busReq), .busAddr(busAddr),
    .busDone(busDone), .busData(busData), .chanCode(chanCode), .rxValid(rxValid),
    .rxByte(rxByte)
  );

  int checks = 0;
  int failures = 0;
  bit finished = 0;

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  // device model and interrupt sources
  int pend[4];
  int served[4];
  logic [7:0] isrVal[4];
  logic [7:0] lsrVal[4];
  logic [7:0] rhrVal[4];
  int lsrReads[4];
  int rhrReads[4];
  int lat = 1;
  int waitCnt = 0;
  logic [7:0] gotByte[$];
  int gotCode[$];

  always_comb for (int i = 0; i < 4; i++) irqLines[i] = (pend[i] > served[i]);

  // reference model: 0 idle, 1 isr read, 2 lsr read, 3 rhr read, 4 deliver
  int mSt = 0;
  int mCode = 0;
  logic [7:0] mData = 8'h00;

  always @(posedge clk) begin
    if (!rstN) begin
      mSt = 0; mCode = 0; mData = 8'h00;
    end else begin
      case (mSt)
        0: for (int i = 0; i < 4; i++)
             if (irqLines[i] && mSt == 0) begin mSt = 1; mCode = i + 1; end
        1: if (busDone) begin mData = busData; mSt = 2; end
        2: if (mData != 8'h04) mSt = 0;
           else if (busDone) begin mData = busData; mSt = 3; end
        3: if (!mData[0]) mSt = 0;
           else if (busDone) begin mData = busData; mSt = 4; end
        default: mSt = 0;
      endcase
    end
  end

  always @(negedge clk) begin
    bit expReq, expValid;
    int expAddr;
    expReq = (mSt == 1) || (mSt == 2 && mData == 8'h04) || (mSt == 3 && mData[0]);
    expValid = (mSt == 4);
    expAddr = (mSt == 1) ? 2 : (mSt == 2) ? 5 : 0;
    chk(busReq == expReq, "R3 busReq", busReq, expReq);
    chk(rxValid == expValid, "R6 rxValid", rxValid, expValid);
    if (expReq) begin
      chk(busAddr == expAddr, "R4 busAddr", busAddr, expAddr);
      chk(chanCode == mCode, "R2 chanCode", chanCode, mCode);
    end
    if (expValid) begin
      chk(rxByte == mData, "R6 rxByte", rxByte, mData);
      chk(chanCode == mCode, "R6 chanCode", chanCode, mCode);
    end
    if (rstN && rxValid) begin
      gotByte.push_back(rxByte);
      gotCode.push_back(chanCode);
      if (chanCode >= 1 && chanCode <= 4) served[chanCode-1]++;
    end
    // bus-cycle generator
    if (!busReq || busDone) begin
      busDone = 1'b0;
      waitCnt = lat;
    end else if (waitCnt == 0) begin
      int ch;
      ch = (chanCode >= 1 && chanCode <= 4) ? chanCode - 1 : 0;
      busDone = 1'b1;
      case (busAddr)
        3'd2: busData = isrVal[ch];
        3'd5: begin busData = lsrVal[ch]; lsrReads[ch]++; end
        default: begin busData = rhrVal[ch]; rhrVal[ch]++; rhrReads[ch]++; end
      endcase
    end else begin
      waitCnt--;
    end
  end

  task automatic summary();
    if (!finished) begin
      finished = 1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  endtask

  int cyc = 0;
  always @(posedge clk) begin
    cyc++;
    if (cyc > 100000) begin
      failures++;
      $display("FAIL watchdog actual=%0d expected=%0d", cyc, 100000);
      summary();
    end
  end

  task automatic waitBytes(input int n);
    for (int k = 0; k < 2000 && gotByte.size() < n; k++) @(negedge clk);
    chk(gotByte.size() >= n, "R6 byte count", gotByte.size(), n);
  endtask

  task automatic settle(input int n);
    repeat (n) @(posedge clk);
    #1;
  endtask

  task automatic clearLog();
    gotByte.delete();
    gotCode.delete();
  endtask

  initial begin
    busDone = 1'b0;
    busData = 8'h00;
    rstN = 1'b0;
    for (int i = 0; i < 4; i++) begin
      pend[i] = 0; served[i] = 0;
      isrVal[i] = 8'h04; lsrVal[i] = 8'h01;
      rhrVal[i] = 8'h10 * (i + 1);
      lsrReads[i] = 0; rhrReads[i] = 0;
    end
    pend[1] = 1; // line high during reset must not start anything
    repeat (3) @(posedge clk);
    @(negedge clk);
    chk(busReq == 1'b0, "R1 busReq in reset", busReq, 0);
    chk(rxValid == 1'b0, "R1 rxValid in reset", rxValid, 0);
    chk(chanCode == 3'd0, "R1 chanCode in reset", chanCode, 0);
    pend[1] = 0;
    @(posedge clk); #1 rstN = 1'b1;
    @(negedge clk);
    chk(busReq == 1'b0 && rxValid == 1'b0, "R1 quiet after reset", busReq, 0);

    // single channel, short latency
    rhrVal[0] = 8'h5A;
    pend[0] = 1;
    waitBytes(1);
    chk(gotByte[0] == 8'h5A, "R6 byte A", gotByte[0], 8'h5A);
    chk(gotCode[0] == 1, "R2 code A", gotCode[0], 1);
    settle(5); clearLog();

    // all four pending together
    lat = 2;
    rhrVal[0] = 8'hA0; rhrVal[1] = 8'hB0; rhrVal[2] = 8'hC0; rhrVal[3] = 8'hD0;
    for (int i = 0; i < 4; i++) pend[i]++;
    waitBytes(4);
    for (int i = 0; i < 4 && i < gotCode.size(); i++) begin
      chk(gotCode[i] == i + 1, "R7 service order", gotCode[i], i + 1);
      chk(gotByte[i] == 8'hA0 + 8'h10 * i, "R7 byte per channel", gotByte[i], 8'hA0 + 8'h10 * i);
    end
    settle(5); clearLog();

    // interrupt status not "data ready"
    begin
      int l0;
      l0 = lsrReads[1];
      isrVal[1] = 8'hC1;
      pend[1]++;
      settle(40);
      chk(gotByte.size() == 0, "R4 no byte on bad status", gotByte.size(), 0);
      chk(lsrReads[1] == l0, "R4 no line status read", lsrReads[1] - l0, 0);
      pend[1] = served[1];
      settle(10);
      isrVal[1] = 8'h04;
    end
    clearLog();

    // line status without data
    begin
      int r0;
      r0 = rhrReads[2];
      lsrVal[2] = 8'h60;
      pend[2]++;
      settle(40);
      chk(gotByte.size() == 0, "R5 no byte when bit0 clear", gotByte.size(), 0);
      chk(rhrReads[2] == r0, "R5 no holding read", rhrReads[2] - r0, 0);
      pend[2] = served[2];
      settle(10);
      lsrVal[2] = 8'h01;
    end
    clearLog();

    // higher-priority line raised during service of line 3
    lat = 4;
    pend[3]++;
    for (int k = 0; k < 200 && !(busReq && chanCode == 3'd4); k++) @(negedge clk);
    @(posedge clk); #1 pend[0]++;
    waitBytes(2);
    if (gotCode.size() >= 2) begin
      chk(gotCode[0] == 4, "R8 in-service channel first", gotCode[0], 4);
      chk(gotCode[1] == 1, "R8 raised line served after", gotCode[1], 1);
    end
    settle(5); clearLog();

    // long waits, several bytes from one channel
    lat = 7;
    rhrVal[0] = 8'h30;
    pend[0] += 3;
    waitBytes(3);
    for (int i = 0; i < 3 && i < gotByte.size(); i++)
      chk(gotByte[i] == 8'h30 + i, "R3 byte under long wait", gotByte[i], 8'h30 + i);
    settle(5); clearLog();

    // zero wait, two channels
    lat = 0;
    pend[2] += 2; pend[1] += 1;
    waitBytes(3);
    if (gotCode.size() >= 3) begin
      chk(gotCode[0] == 2, "R7 zero wait first", gotCode[0], 2);
      chk(gotCode[1] == 3 && gotCode[2] == 3, "R7 zero wait rest", gotCode[2], 3);
    end
    settle(10);
    summary();
  end
endmodule